// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block sits beside a simple in-order core and turns fault reports into an exception entry. Each cycle the core may present one general fault and one debug request. A general fault is a plain cause code, a bus transaction error or a misaligned access. The block chooses the cause code, records the faulting PC and, when one is supplied, the faulting virtual address. It updates the processor status word and issues a one-cycle take strobe together with a one-hot vector select. The core's pipeline flush and its vector address table consume that strobe and select.

The vector is chosen from the exception-mode and user-mode bits of the status word. A fault that arrives while exception mode is already set is a nested fault. Its PC goes to a separate double-fault PC register when that register is built, and to the first-level PC register when it is not. A debug request is accepted only when the current interrupt level is below the configured debug level. On entry it saves the PC and the old status word into the save registers for that level and raises the interrupt level. Software reads and writes every state register through a simple register port.

Top module: `exc_dispatch`

## Requirements
- R1: When the exception-mode bit (status bit 4) is clear, a general fault writes its PC into the first-level PC register (address 1). It selects the user vector (vec_o bit 1) when the user-mode bit (status bit 5) is set, and the kernel vector (vec_o bit 0) otherwise.
- R2: When the exception-mode bit is set, a general fault selects the double vector (vec_o bit 2). Its PC goes to the double-fault PC register (address 2) when HAS_DEPC is nonzero, and the first-level PC register is then left unchanged. When HAS_DEPC is zero, the PC goes to the first-level PC register.
- R3: Every general fault writes its resolved cause into the cause register (address 3) and sets the exception-mode bit. All other status bits are kept.
- R4: A general fault with exc_has_addr_i high writes exc_vaddr_i into the fault address register (address 4). Without it, that register keeps its value.
- R5: A bus error (exc_kind_i = 1) resolves to cause FETCH_ERR_CAUSE (default 12) when exc_fetch_i is high, and to DATA_ERR_CAUSE (default 13) when it is low.
- R6: A misaligned access (exc_kind_i = 2) resolves to ALIGN_CAUSE (default 9) only when TRAP_UNALIGNED is nonzero and HW_ALIGN is zero. Otherwise it produces no strobe and changes no register.
- R7: A debug request is taken only when the interrupt level (status bits 3:0) is below DEBUG_LEVEL. Otherwise it produces no strobe and changes no register.
- R8: A taken debug request writes dbg_cause_i into the debug cause register (address 5), the PC into the level PC register (address 8+level) and the old status into the level status register (address 16+level). It sets the interrupt level to DEBUG_LEVEL and sets the exception-mode bit. The user-mode bit and the cause register are kept.
- R9: When a debug request is taken in the same cycle as a general fault, only the debug entry happens and the general fault is discarded. When the debug request is refused, the general fault is taken.
- R10: take_o is high for exactly one cycle, in the cycle after the request. vec_o is one-hot (bit 0 kernel, 1 user, 2 double, 3 debug) while take_o is high and zero otherwise.
- R11: A register written through the register port reads back its value; the status register keeps only bits 5:0. When an exception updates a register in the same cycle as a software write to it, the exception value wins.
- R12: After reset the status register reads 0x1F, every other register reads zero, and take_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 1 | General fault request |
| exc_kind_i | input | 2 | 0 plain cause, 1 bus error, 2 misaligned |
| exc_cause_i | input | 8 | Cause code for plain faults |
| exc_fetch_i | input | 1 | Bus error came from an instruction fetch |
| exc_has_addr_i | input | 1 | Fault carries a virtual address |
| exc_vaddr_i | input | 32 | Faulting virtual address |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| dbg_req_i | input | 1 | Debug request |
| dbg_cause_i | input | 8 | Debug cause bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| take_o | output | 1 | Take-exception strobe |
| vec_o | output | 4 | One-hot vector select |

## Verification
The bench goes after the nested fault and checks that the first-level PC survives when the double-fault register exists. A design that ignored exception mode would instead dispatch to the kernel vector and overwrite the return PC. It raises a debug request at exactly the debug level, where a design that compared with less-or-equal would take it and clobber the level save registers. It fires debug and general requests together at both sides of that threshold: a wrong priority would leak the general cause into the cause register, and a wrong refusal path would drop the general fault. A second instance with hardware alignment and no double-fault register confirms that a misaligned access leaves it silent and that its nested PC lands in the first-level register.

// File: rtl/exc_dispatch_pkg.sv
// Shared constants and types for the exception dispatch unit.
// Assumes a 32-bit machine word and a status word whose low six bits are
// architectural (interrupt level, exception mode, user mode).
package exc_dispatch_pkg;
    localparam int XLEN       = 32;
    localparam int CAUSE_W    = 8;
    localparam int REG_ADDR_W = 5;
    localparam int IL_W       = 4;
    localparam int NUM_VEC    = 4;

    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;

    localparam logic [XLEN-1:0] PS_IL_MASK   = 32'h0000_000F;
    localparam logic [XLEN-1:0] PS_EXCM_MASK = 32'h0000_0010;
    localparam logic [XLEN-1:0] PS_WMASK     = 32'h0000_003F;
    localparam logic [XLEN-1:0] PS_RESET     = 32'h0000_001F;

    typedef enum logic [1:0] {
        KIND_PLAIN    = 2'd0,
        KIND_BUSERR   = 2'd1,
        KIND_MISALIGN = 2'd2,
        KIND_RSVD     = 2'd3
    } req_kind_e;

    // Vector select bit positions
    localparam int VEC_KERNEL = 0;
    localparam int VEC_USER   = 1;
    localparam int VEC_DOUBLE = 2;
    localparam int VEC_DEBUG  = 3;

    // Register map
    localparam int RA_PS       = 0;
    localparam int RA_EPC1     = 1;
    localparam int RA_DEPC     = 2;
    localparam int RA_CAUSE    = 3;
    localparam int RA_VADDR    = 4;
    localparam int RA_DBGCAUSE = 5;
    localparam int RA_EPC_BASE = 8;
    localparam int RA_EPS_BASE = 16;

    typedef struct packed {
        logic [XLEN-1:0]    pc;
        logic [XLEN-1:0]    vaddr;
        logic [CAUSE_W-1:0] cause;
        logic               has_addr;
    } exc_info_t;
endpackage

// File: rtl/exc_cause_resolve.sv
// Resolves a general fault report into a valid flag and a final cause code.
// Assumes the core holds the request for the single cycle it is sampled.
module exc_cause_resolve
    import exc_dispatch_pkg::*;
#(
    parameter int TRAP_UNALIGNED  = 1,
    parameter int HW_ALIGN        = 0,
    parameter int FETCH_ERR_CAUSE = 12,
    parameter int DATA_ERR_CAUSE  = 13,
    parameter int ALIGN_CAUSE     = 9
) (
    input  logic               req_i,
    input  logic [1:0]         kind_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               fetch_i,
    output logic               valid_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic ALIGN_TRAPS = (TRAP_UNALIGNED != 0) && (HW_ALIGN == 0);
    localparam logic [CAUSE_W-1:0] FETCH_C = CAUSE_W'(FETCH_ERR_CAUSE);
    localparam logic [CAUSE_W-1:0] DATA_C  = CAUSE_W'(DATA_ERR_CAUSE);
    localparam logic [CAUSE_W-1:0] ALIGN_C = CAUSE_W'(ALIGN_CAUSE);

    // Pick the cause by fault kind and drop misaligned faults when not trapped
    always_comb begin
        valid_o = req_i;
        cause_o = cause_i;
        case (req_kind_e'(kind_i))
            KIND_BUSERR:   cause_o = fetch_i ? FETCH_C : DATA_C;
            KIND_MISALIGN: begin
                cause_o = ALIGN_C;
                valid_o = req_i && ALIGN_TRAPS;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_arbiter.sv
// Decides which request is taken this cycle: an accepted debug request
// beats a general fault. Assumes the interrupt level comes from the
// current status register.
module exc_arbiter
    import exc_dispatch_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6
) (
    input  logic            gen_valid_i,
    input  logic            dbg_req_i,
    input  logic [IL_W-1:0] cur_il_i,
    output logic            take_gen_o,
    output logic            take_dbg_o
);
    localparam logic [IL_W-1:0] DBG_IL = IL_W'(DEBUG_LEVEL);

    logic dbg_ok;

    // Gate debug by interrupt level, then grant at most one request
    always_comb begin
        dbg_ok     = dbg_req_i && (cur_il_i < DBG_IL);
        take_dbg_o = dbg_ok;
        take_gen_o = gen_valid_i && !dbg_ok;
    end
endmodule

// File: rtl/exc_state_regs.sv
// Exception state registers: status word, first-level PC, double-fault PC,
// cause, fault address, debug cause, and PC/status save registers per level.
// Assumes at most one of take_gen_i / take_dbg_i is high; exception updates
// override a software write in the same cycle.
module exc_state_regs
    import exc_dispatch_pkg::*;
#(
    parameter int HAS_DEPC    = 1,
    parameter int DEBUG_LEVEL = 6,
    parameter int LVL_MIN     = 2,
    parameter int LVL_MAX     = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_gen_i,
    input  logic                  take_dbg_i,
    input  exc_info_t             info_i,
    input  logic [CAUSE_W-1:0]    dbg_cause_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [XLEN-1:0]       wdata_i,
    output logic [XLEN-1:0]       rdata_o,
    output logic [IL_W-1:0]       ps_il_o,
    output logic                  ps_excm_o,
    output logic                  ps_um_o
);
    localparam int NLVL = LVL_MAX - LVL_MIN + 1;
    localparam logic [IL_W-1:0] DBG_IL = IL_W'(DEBUG_LEVEL);

    logic [XLEN-1:0] ps_q, epc1_q, depc_q, cause_q, vaddr_q, dbgcause_q;
    logic [XLEN-1:0] ps_dbg_next;
    logic [NLVL-1:0][XLEN-1:0] epc_all, eps_all;
    int addr_int;

    assign addr_int = int'(addr_i);

    // Status value after debug entry: level raised, exception mode set
    always_comb begin
        ps_dbg_next = (ps_q & ~PS_IL_MASK) | PS_EXCM_MASK
                      | {{(XLEN-IL_W){1'b0}}, DBG_IL};
    end

    // Main register update: software write first, exception entry overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q       <= PS_RESET;
            epc1_q     <= '0;
            depc_q     <= '0;
            cause_q    <= '0;
            vaddr_q    <= '0;
            dbgcause_q <= '0;
        end else begin
            if (wr_i) begin
                case (addr_int)
                    RA_PS:       ps_q       <= wdata_i & PS_WMASK;
                    RA_EPC1:     epc1_q     <= wdata_i;
                    RA_DEPC:     if (HAS_DEPC != 0) depc_q <= wdata_i;
                    RA_CAUSE:    cause_q    <= wdata_i;
                    RA_VADDR:    vaddr_q    <= wdata_i;
                    RA_DBGCAUSE: dbgcause_q <= wdata_i;
                    default: ;
                endcase
            end
            if (take_gen_i) begin
                if (ps_q[PS_EXCM_BIT] && (HAS_DEPC != 0)) begin
                    depc_q <= info_i.pc;
                end else begin
                    epc1_q <= info_i.pc;
                end
                cause_q <= {{(XLEN-CAUSE_W){1'b0}}, info_i.cause};
                if (info_i.has_addr) begin
                    vaddr_q <= info_i.vaddr;
                end
                ps_q <= ps_q | PS_EXCM_MASK;
            end
            if (take_dbg_i) begin
                dbgcause_q <= {{(XLEN-CAUSE_W){1'b0}}, dbg_cause_i};
                ps_q       <= ps_dbg_next;
            end
        end
    end

    // One PC/status save pair per interrupt level
    for (genvar l = LVL_MIN; l <= LVL_MAX; l++) begin : g_lvl
        logic [XLEN-1:0] epc_r, eps_r;

        // Save on debug entry at this level, else take software writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                epc_r <= '0;
                eps_r <= '0;
            end else begin
                if (wr_i && (addr_int == RA_EPC_BASE + l)) epc_r <= wdata_i;
                if (wr_i && (addr_int == RA_EPS_BASE + l)) eps_r <= wdata_i & PS_WMASK;
                if (take_dbg_i && (l == DEBUG_LEVEL)) begin
                    epc_r <= info_i.pc;
                    eps_r <= ps_q;
                end
            end
        end

        assign epc_all[l-LVL_MIN] = epc_r;
        assign eps_all[l-LVL_MIN] = eps_r;
    end

    // Read multiplexer for the register port
    always_comb begin
        rdata_o = '0;
        case (addr_int)
            RA_PS:       rdata_o = ps_q;
            RA_EPC1:     rdata_o = epc1_q;
            RA_DEPC:     rdata_o = depc_q;
            RA_CAUSE:    rdata_o = cause_q;
            RA_VADDR:    rdata_o = vaddr_q;
            RA_DBGCAUSE: rdata_o = dbgcause_q;
            default: ;
        endcase
        for (int l = LVL_MIN; l <= LVL_MAX; l++) begin
            if (addr_int == RA_EPC_BASE + l) rdata_o = epc_all[l-LVL_MIN];
            if (addr_int == RA_EPS_BASE + l) rdata_o = eps_all[l-LVL_MIN];
        end
    end

    assign ps_il_o   = ps_q[IL_W-1:0];
    assign ps_excm_o = ps_q[PS_EXCM_BIT];
    assign ps_um_o   = ps_q[PS_UM_BIT];

    // R2: with a double-fault register, a nested fault leaves the first-level PC alone
    p_epc1_kept_nested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DEPC != 0) && take_gen_i && ps_q[PS_EXCM_BIT] && !wr_i |=> $stable(epc1_q));

    // R4: a fault without an address keeps the fault address register
    p_vaddr_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_gen_i && !info_i.has_addr && !wr_i |=> $stable(vaddr_q));

    // R8: debug entry raises the interrupt level to the debug level with exception mode
    p_debug_level_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_dbg_i |=> (ps_q[IL_W-1:0] == DBG_IL) && ps_q[PS_EXCM_BIT]);
endmodule

// File: rtl/exc_dispatch.sv
// Exception dispatch unit top: resolves the fault cause, arbitrates debug
// against general faults, updates the state registers and registers the
// take strobe and one-hot vector select. Assumes DEBUG_LEVEL is in 2..7.
module exc_dispatch
    import exc_dispatch_pkg::*;
#(
    parameter int HAS_DEPC        = 1,
    parameter int DEBUG_LEVEL     = 6,
    parameter int TRAP_UNALIGNED  = 1,
    parameter int HW_ALIGN        = 0,
    parameter int FETCH_ERR_CAUSE = 12,
    parameter int DATA_ERR_CAUSE  = 13,
    parameter int ALIGN_CAUSE     = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exc_req_i,
    input  logic [1:0]            exc_kind_i,
    input  logic [CAUSE_W-1:0]    exc_cause_i,
    input  logic                  exc_fetch_i,
    input  logic                  exc_has_addr_i,
    input  logic [XLEN-1:0]       exc_vaddr_i,
    input  logic [XLEN-1:0]       exc_pc_i,
    input  logic                  dbg_req_i,
    input  logic [CAUSE_W-1:0]    dbg_cause_i,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [XLEN-1:0]       reg_wdata_i,
    output logic [XLEN-1:0]       reg_rdata_o,
    output logic                  take_o,
    output logic [NUM_VEC-1:0]    vec_o
);
    localparam logic [IL_W-1:0] DBG_IL = IL_W'(DEBUG_LEVEL);

    logic               gen_valid;
    logic [CAUSE_W-1:0] gen_cause;
    logic               take_gen, take_dbg;
    logic [IL_W-1:0]    ps_il;
    logic               ps_excm, ps_um;
    logic [NUM_VEC-1:0] vec_next;
    exc_info_t          info;

    exc_cause_resolve #(
        .TRAP_UNALIGNED (TRAP_UNALIGNED),
        .HW_ALIGN       (HW_ALIGN),
        .FETCH_ERR_CAUSE(FETCH_ERR_CAUSE),
        .DATA_ERR_CAUSE (DATA_ERR_CAUSE),
        .ALIGN_CAUSE    (ALIGN_CAUSE)
    ) u_cause (
        .req_i  (exc_req_i),
        .kind_i (exc_kind_i),
        .cause_i(exc_cause_i),
        .fetch_i(exc_fetch_i),
        .valid_o(gen_valid),
        .cause_o(gen_cause)
    );

    exc_arbiter #(
        .DEBUG_LEVEL(DEBUG_LEVEL)
    ) u_arb (
        .gen_valid_i(gen_valid),
        .dbg_req_i  (dbg_req_i),
        .cur_il_i   (ps_il),
        .take_gen_o (take_gen),
        .take_dbg_o (take_dbg)
    );

    assign info.pc       = exc_pc_i;
    assign info.vaddr    = exc_vaddr_i;
    assign info.cause    = gen_cause;
    assign info.has_addr = exc_has_addr_i;

    exc_state_regs #(
        .HAS_DEPC   (HAS_DEPC),
        .DEBUG_LEVEL(DEBUG_LEVEL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_gen_i (take_gen),
        .take_dbg_i (take_dbg),
        .info_i     (info),
        .dbg_cause_i(dbg_cause_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .ps_il_o    (ps_il),
        .ps_excm_o  (ps_excm),
        .ps_um_o    (ps_um)
    );

    // Vector choice from the status bits seen before the entry
    always_comb begin
        vec_next = '0;
        if (take_dbg) begin
            vec_next[VEC_DEBUG] = 1'b1;
        end else if (take_gen) begin
            if (ps_excm)    vec_next[VEC_DOUBLE] = 1'b1;
            else if (ps_um) vec_next[VEC_USER]   = 1'b1;
            else            vec_next[VEC_KERNEL] = 1'b1;
        end
    end

    // Register the strobe and vector so both leave the block together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            vec_o  <= '0;
        end else begin
            take_o <= take_gen || take_dbg;
            vec_o  <= vec_next;
        end
    end

    // R10: exactly one vector bit while the strobe is high
    p_vec_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(vec_o) == 1));

    // R10: no vector bit without a strobe
    p_vec_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vec_o == '0));

    // R3: every entry leaves exception mode set
    p_excm_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ps_excm);

    // R2: the double vector only follows a fault raised in exception mode
    p_double_needs_excm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && vec_o[VEC_DOUBLE] |-> $past(ps_excm));

    // R7: a debug entry only happens below the debug level
    p_debug_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && vec_o[VEC_DEBUG] |-> ($past(ps_il) < DBG_IL));

    // R9: an acceptable debug request always wins the cycle
    p_debug_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req_i && (ps_il < DBG_IL) |=> take_o && vec_o[VEC_DEBUG]);

    // R1: a first-level kernel fault dispatches to the kernel vector
    p_kernel_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_gen && !ps_excm && !ps_um |=> take_o && vec_o[VEC_KERNEL]);
endmodule

// File: tb/exc_dispatch_tb_top.sv
`timescale 1ns/1ps
module exc_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [1:0]  exc_kind = 2'd0;
    logic [7:0]  exc_cause = 8'd0;
    logic        exc_fetch = 1'b0;
    logic        exc_has = 1'b0;
    logic [31:0] exc_vaddr = 32'd0;
    logic [31:0] exc_pc = 32'd0;
    logic        dbg_req = 1'b0;
    logic [7:0]  dbg_cause = 8'd0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rdata, rdata2;
    logic        take, take2;
    logic [3:0]  vec, vec2;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    exc_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_kind_i(exc_kind),
        .exc_cause_i(exc_cause), .exc_fetch_i(exc_fetch), .exc_has_addr_i(exc_has),
        .exc_vaddr_i(exc_vaddr), .exc_pc_i(exc_pc), .dbg_req_i(dbg_req),
        .dbg_cause_i(dbg_cause), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .take_o(take), .vec_o(vec));

    exc_dispatch #(.HAS_DEPC(0), .HW_ALIGN(1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_kind_i(exc_kind),
        .exc_cause_i(exc_cause), .exc_fetch_i(exc_fetch), .exc_has_addr_i(exc_has),
        .exc_vaddr_i(exc_vaddr), .exc_pc_i(exc_pc), .dbg_req_i(dbg_req),
        .dbg_cause_i(dbg_cause), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata2), .take_o(take2), .vec_o(vec2));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input int addr, input logic [31:0] exp);
        reg_addr = 5'(addr);
        #0.5;
        chk(tag, rdata, exp);
    endtask

    task automatic rd_alt(input string tag, input int addr, input logic [31:0] exp);
        reg_addr = 5'(addr);
        #0.5;
        chk(tag, rdata2, exp);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: present one request for one edge and push the expected vector
    task automatic fire(input logic g, input logic [1:0] kind, input logic [7:0] cause,
                        input logic fetch, input logic has, input logic [31:0] va,
                        input logic d, input logic [7:0] dc, input logic [31:0] pc,
                        input logic [3:0] expv, input string tag);
        @(negedge clk);
        exc_req = g; exc_kind = kind; exc_cause = cause; exc_fetch = fetch;
        exc_has = has; exc_vaddr = va; dbg_req = d; dbg_cause = dc; exc_pc = pc;
        @(posedge clk);
        if (expv != 4'd0) begin
            exp_q.push_back(expv);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        exc_req = 1'b0; dbg_req = 1'b0;
    endtask

    // Monitor: compare every strobe with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (take) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 spurious strobe actual vec=%b expected none", vec);
                end else begin
                    automatic logic [3:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk({t, " vector"}, {28'd0, vec}, {28'd0, e});
                end
            end else if (exp_q.size() != 0) begin
                automatic logic [3:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                checks++; failures++;
                $display("FAIL %s missing strobe actual vec=%b expected=%b", t, vec, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd("R12 status", 0, 32'h1F);
        rd("R12 cause", 3, 32'h0);
        rd("R12 level pc", 14, 32'h0);
        chk("R12 take", {31'd0, take}, 32'd0);

        // R11 status write keeps bits 5:0
        wr(0, 32'hFFFF_FFC0);
        rd("R11 status mask", 0, 32'h0);

        // R1 R3 R4 kernel fault with address
        fire(1, 2'd0, 8'd5, 0, 1, 32'hDEAD_0000, 0, 8'd0, 32'h1000, 4'b0001, "R1 kernel");
        rd("R1 pc", 1, 32'h1000);
        rd("R3 cause", 3, 32'h5);
        rd("R3 status", 0, 32'h10);
        rd("R4 vaddr", 4, 32'hDEAD_0000);
        @(negedge clk);
        chk("R10 single pulse", {27'd0, take, vec}, 32'd0);

        // R2 nested fault, no address
        fire(1, 2'd0, 8'd7, 0, 0, 32'h0BAD_0BAD, 0, 8'd0, 32'h2000, 4'b0100, "R2 double");
        rd("R2 depc", 2, 32'h2000);
        rd("R2 first pc kept", 1, 32'h1000);
        rd("R4 vaddr kept", 4, 32'hDEAD_0000);
        rd("R3 cause nested", 3, 32'h7);
        rd_alt("R2 no depc pc", 1, 32'h2000);
        rd_alt("R2 no depc reg", 2, 32'h0);

        // R5 fetch bus error from user mode
        wr(0, 32'h20);
        fire(1, 2'd1, 8'd0, 1, 1, 32'h3004, 0, 8'd0, 32'h3000, 4'b0010, "R1 user");
        rd("R5 fetch cause", 3, 32'd12);
        rd("R5 vaddr", 4, 32'h3004);
        rd("R1 user pc", 1, 32'h3000);
        rd("R3 status keeps um", 0, 32'h30);

        // R5 data bus error
        wr(0, 32'h0);
        fire(1, 2'd1, 8'd0, 0, 1, 32'h5000, 0, 8'd0, 32'h3100, 4'b0001, "R5 data");
        rd("R5 data cause", 3, 32'd13);

        // R6 misaligned: trapped on dut_i, silent on the alternate instance
        wr(0, 32'h0);
        fire(1, 2'd2, 8'd0, 0, 1, 32'h4001, 0, 8'd0, 32'h4000, 4'b0001, "R6 align");
        chk("R6 alt no strobe", {31'd0, take2}, 32'd0);
        rd("R6 align cause", 3, 32'd9);
        rd_alt("R6 alt cause kept", 3, 32'd13);
        rd_alt("R6 alt status kept", 0, 32'h0);

        // R7 R8 debug entry below the level
        wr(0, 32'h23);
        fire(0, 2'd0, 8'd0, 0, 0, 32'h0, 1, 8'h11, 32'h6000, 4'b1000, "R8 debug");
        rd("R8 debug cause", 5, 32'h11);
        rd("R8 level pc", 14, 32'h6000);
        rd("R8 level status", 22, 32'h23);
        rd("R8 status", 0, 32'h36);
        rd("R8 cause kept", 3, 32'd9);

        // R7 debug at the level is refused
        fire(0, 2'd0, 8'd0, 0, 0, 32'h0, 1, 8'h02, 32'h6100, 4'b0000, "R7 gated");
        chk("R7 no strobe", {31'd0, take}, 32'd0);
        rd("R7 debug cause kept", 5, 32'h11);
        rd("R7 status kept", 0, 32'h36);
        rd("R7 level pc kept", 14, 32'h6000);

        // R9 debug wins over a simultaneous fault
        wr(0, 32'h05);
        fire(1, 2'd0, 8'd4, 0, 0, 32'h0, 1, 8'h03, 32'h7000, 4'b1000, "R9 debug wins");
        rd("R9 cause untouched", 3, 32'd9);
        rd("R9 first pc untouched", 1, 32'h4000);
        rd("R9 level pc", 14, 32'h7000);
        rd("R9 level status", 22, 32'h05);

        // R9 refused debug lets the fault through
        wr(0, 32'h06);
        fire(1, 2'd0, 8'd4, 0, 0, 32'h0, 1, 8'h03, 32'h7100, 4'b0001, "R9 fault taken");
        rd("R9 fault cause", 3, 32'd4);
        rd("R9 fault pc", 1, 32'h7100);
        rd("R9 debug cause kept", 5, 32'h03);

        // R11 exception beats a same-cycle software write
        wr(0, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd3; reg_wdata = 32'hAA;
        fire(1, 2'd0, 8'd8, 0, 0, 32'h0, 0, 8'd0, 32'h8000, 4'b0001, "R11 collide");
        reg_wr = 1'b0;
        rd("R11 exception wins", 3, 32'd8);
        wr(4, 32'h1234_5678);
        rd("R11 readback", 4, 32'h1234_5678);
        wr(19, 32'hCAFE_0000);
        rd("R11 level pc write", 11, 32'h0);
        rd("R11 level status write", 19, 32'h0);

        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule